// File: doc/BRIEF.md
# Pulse-Stepped Setpoint Counter

This block keeps the 6-bit code that drives a current-output DAC setting a supply's output voltage. Two slow, asynchronous control pins drive it: a mode pin and an adjust pin. Both are brought into the clock domain through flop chains and decoded into one of three operating states: shutdown, return to mid-scale, or run.

In run, each rising edge of the adjust pin moves the code up by one. Past the top code the counter wraps to zero. A controller that only pulses one wire can therefore lower the setting by one step with 63 pulses. The code starts at mid-scale after reset and whenever mid-scale is requested. Shutdown freezes the code, so the previous setting comes back when the block is enabled again.

Top module: `setpoint_stepper`

## Requirements
- R1: While reset (synchronous, active high) is applied, and on the edge it is sampled, the code becomes 32 and both shutdown_o and enable_o are low.
- R2: shutdown_o and enable_o are never high at the same time.
- R3: With mode_pin high, every rising edge of adj_pin adds exactly one to code_o, and the code changes at no other time while running.
- R4: Adding one to code 63 gives code 0, so 64 pulses return the code to its start value and 63 pulses lower it by one.
- R5: With mode_pin low and adj_pin low, shutdown_o is high, enable_o is low and code_o keeps its value.
- R6: With mode_pin low and adj_pin high, code_o is forced to 32 and both shutdown_o and enable_o are low.
- R7: With mode_pin high, enable_o is high and shutdown_o is low; a steady adj_pin level or a falling adj_pin edge leaves code_o unchanged.
- R8: An adj_pin rising edge that reaches the decoder in the same cycle as mode_pin going high does not change the code.
- R9: A pin change driven between clock edges appears at the outputs after the third rising clock edge, and not after the second (two synchronizer stages plus the output register).

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_pin | input | 1 | Asynchronous mode control (high = run) |
| adj_pin | input | 1 | Asynchronous adjust control (rising edge steps; level selects mid-scale while mode is low) |
| code_o | output | CODE_W (6) | DAC code, registered |
| shutdown_o | output | 1 | High in the shutdown state, registered |
| enable_o | output | 1 | High in the run state, registered |

## Verification
The stepping function is driven through a full ring of 64 pulses from mid-scale, with every intermediate code checked against (32 + n) mod 64. A further 63 pulses separate a correct wrap from a saturating or down-counting one. Steady-high and falling adjust levels show that only rising edges count. Entering run with both pins rising together tells the edge gate apart from a plain edge detector. Shutdown entered from a non-mid code shows whether the value is held or reloaded, and a cycle-by-cycle probe of shutdown entry pins down the synchronizer depth.

// File: rtl/setpt_pkg.sv
package setpt_pkg;
  typedef enum logic [1:0] {
    OP_SHUT = 2'd0,
    OP_MID  = 2'd1,
    OP_RUN  = 2'd2
  } op_mode_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/mode_decode.sv
module mode_decode
  import setpt_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     mode_s,
  input  logic     adj_s,
  output op_mode_t op,
  output logic     step
);
  logic adj_q;
  logic run_q;
  logic run_now;

  always_comb begin
    if (mode_s)     op = OP_RUN;
    else if (adj_s) op = OP_MID;
    else            op = OP_SHUT;
  end

  assign run_now = (op == OP_RUN);

  // an edge counts only if run was already active in the previous cycle
  assign step = run_now && run_q && adj_s && !adj_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      adj_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      adj_q <= adj_s;
      run_q <= run_now;
    end
  end
endmodule

// File: rtl/step_counter.sv
module step_counter
  import setpt_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  op_mode_t          op,
  input  logic              step,
  output logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] MID_CODE = 1 << (CODE_W - 1);
  localparam logic [CODE_W-1:0] ONE      = 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= MID_CODE;
    end else begin
      case (op)
        OP_MID:  code <= MID_CODE;
        OP_RUN:  if (step) code <= code + ONE;
        default: code <= code;
      endcase
    end
  end
endmodule

// File: rtl/setpoint_stepper.sv
module setpoint_stepper
  import setpt_pkg::*;
#(
  parameter int CODE_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_pin,
  input  logic              adj_pin,
  output logic [CODE_W-1:0] code_o,
  output logic              shutdown_o,
  output logic              enable_o
);
  logic [1:0] pins_s;
  op_mode_t   op;
  logic       step;

  pin_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({mode_pin, adj_pin}),
    .dout (pins_s)
  );

  mode_decode u_dec (
    .clk    (clk),
    .rst    (rst),
    .mode_s (pins_s[1]),
    .adj_s  (pins_s[0]),
    .op     (op),
    .step   (step)
  );

  step_counter #(.CODE_W(CODE_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .op   (op),
    .step (step),
    .code (code_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      shutdown_o <= 1'b0;
      enable_o   <= 1'b0;
    end else begin
      shutdown_o <= (op == OP_SHUT);
      enable_o   <= (op == OP_RUN);
    end
  end
endmodule

// File: rtl/setpoint_stepper_chk.sv
module setpoint_stepper_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] code_o,
  input logic              shutdown_o,
  input logic              enable_o
);
  localparam logic [CODE_W-1:0] MID_CODE = 1 << (CODE_W - 1);
  localparam logic [CODE_W-1:0] ONE      = 1;

  a_r1_reset_mid: assert property (@(posedge clk)
    rst |=> (code_o == MID_CODE && !shutdown_o && !enable_o));

  a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(shutdown_o && enable_o));

  // R3, R4: any change while running is a single modular step
  a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
    (enable_o && code_o != $past(code_o)) |-> ((code_o - $past(code_o)) == ONE));

  a_r5_shut_hold: assert property (@(posedge clk) disable iff (rst)
    shutdown_o |-> $stable(code_o));

  a_r6_mid_value: assert property (@(posedge clk) disable iff (rst)
    (!shutdown_o && !enable_o) |-> (code_o == MID_CODE));
endmodule

bind setpoint_stepper setpoint_stepper_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .code_o     (code_o),
  .shutdown_o (shutdown_o),
  .enable_o   (enable_o)
);

// File: tb/sim_setpoint_stepper.sv
`timescale 1ns/1ps
module sim_setpoint_stepper;
  localparam int CODE_W = 6;
  localparam int FULL   = 1 << CODE_W;
  localparam int MID    = FULL / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_pin = 1'b0;
  logic adj_pin = 1'b0;
  logic [CODE_W-1:0] code_o;
  logic shutdown_o;
  logic enable_o;

  int checks = 0;
  int errors = 0;
  int both_high = 0;
  bit done = 1'b0;
  int expv;

  always #4 clk = ~clk;

  setpoint_stepper #(.CODE_W(CODE_W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .mode_pin(mode_pin), .adj_pin(adj_pin),
    .code_o(code_o), .shutdown_o(shutdown_o), .enable_o(enable_o)
  );

  always @(negedge clk) if (!rst && shutdown_o && enable_o) both_high++;

  task automatic check(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic set_pins(input logic m, input logic a);
    @(negedge clk);
    mode_pin = m;
    adj_pin  = a;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse();
    set_pins(1'b1, 1'b1);
    settle();
    set_pins(1'b1, 1'b0);
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 code", code_o, MID);
    check("R1 shutdown", shutdown_o, 0);
    check("R1 enable", enable_o, 0);
    rst = 1'b0;

    // R5: shutdown combination
    settle();
    check("R5 shutdown", shutdown_o, 1);
    check("R5 enable", enable_o, 0);
    check("R5 code", code_o, MID);

    // R6: mid-scale combination
    set_pins(1'b0, 1'b1);
    settle();
    check("R6 code", code_o, MID);
    check("R6 shutdown", shutdown_o, 0);
    check("R6 enable", enable_o, 0);

    // R7: enter run with adjust already high, then falling edge
    set_pins(1'b1, 1'b1);
    settle();
    check("R7 enable", enable_o, 1);
    check("R7 shutdown", shutdown_o, 0);
    check("R7 no step on entry", code_o, MID);
    set_pins(1'b1, 1'b0);
    settle();
    check("R7 falling edge", code_o, MID);

    // R3, R4: full ring of pulses
    for (int n = 1; n <= FULL; n++) begin
      pulse();
      expv = (MID + n) % FULL;
      check((expv == 0) ? "R4 wrap to zero" : "R3 step", code_o, expv);
    end

    // R4: 63 pulses lower the setting by one
    for (int n = 0; n < FULL - 1; n++) pulse();
    check("R4 minus one", code_o, MID - 1);

    // R7: steady high adjust level
    set_pins(1'b1, 1'b1);
    settle();
    check("R3 step before hold", code_o, MID);
    repeat (20) @(negedge clk);
    check("R7 steady level", code_o, MID);
    set_pins(1'b1, 1'b0);
    settle();
    for (int n = 0; n < 4; n++) pulse();
    check("R3 four steps", code_o, MID + 4);

    // R9: latency of shutdown entry
    set_pins(1'b0, 1'b0);
    @(negedge clk);
    @(negedge clk);
    check("R9 not after two edges", shutdown_o, 0);
    @(negedge clk);
    check("R9 after three edges", shutdown_o, 1);
    settle();
    check("R5 code held", code_o, MID + 4);

    // R8: both pins rise together on leaving shutdown
    set_pins(1'b1, 1'b1);
    settle();
    check("R8 enable", enable_o, 1);
    check("R8 coincident edge ignored", code_o, MID + 4);
    set_pins(1'b1, 1'b0);
    settle();
    pulse();
    check("R3 step after run entry", code_o, MID + 5);

    // R6: back to mid-scale from a non-mid code
    set_pins(1'b0, 1'b1);
    settle();
    check("R6 reload", code_o, MID);

    // R1: reset during run after stepping
    set_pins(1'b1, 1'b0);
    settle();
    pulse();
    pulse();
    check("R3 before reset", code_o, MID + 2);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset reload", code_o, MID);
    check("R1 enable low", enable_o, 0);
    rst = 1'b0;
    settle();

    check("R2 never both high", both_high, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule